// File: doc/BRIEF.md
# Thermal Limit Comparator with Hysteresis

This block watches a stream of signed temperature samples and keeps three sticky status flags: critical, high and low. Each flag has two thresholds that differ by a programmable hysteresis. A flag sets when the sample crosses the outer threshold and clears only when the sample comes back past the inner one. Samples arrive as two's complement numbers with a valid strobe. Only the quarter-degree part of a sample is compared, and any finer fraction bits are dropped.

From these flags the block drives an alarm. The alarm can follow the flags as a level (comparator mode) or latch on a new flag rise until software sends a clear (interrupt mode). Three controls shape the alarm: an enable, a critical-only selector and a polarity bit. A shutdown control freezes the flags and blocks new interrupts. The block sits after the converter and beside the register file, which supplies every limit and control as a plain level.

Top module: `thm_limit_monitor`

## Requirements
- R1: Only `temp_i[LIM_W+FINE_W-1:FINE_W]` (0.25 °C per LSB, two's complement) is compared. The low `FINE_W` bits have no effect on any output.
- R2: `hyst_sel_i` selects the hysteresis width: 0 → 0, 1 → 6, 2 → 12, 3 → 24 counts of 0.25 °C.
- R3: `crit_o` sets on an accepted sample above `crit_lim_i`. Once set, it clears only on an accepted sample at or below `crit_lim_i` minus the hysteresis.
- R4: `high_o` follows the same rule as R3, using `high_lim_i`.
- R5: `low_o` sets on an accepted sample below `low_lim_i` minus the hysteresis. Once set, it clears on an accepted sample at or above `low_lim_i`.
- R6: With `crit_only_i`=1, only the critical flag drives the alarm. With `crit_only_i`=0, any of the three flags drives it.
- R7: When `alarm_en_i` is 0 at a clock edge, `evt_o` is 0 after that edge.
- R8: `alarm_pin_o` equals `alarm_pol_i` while `evt_o` is 1 and equals its inverse while `evt_o` is 0 (0 selects active low, 1 selects active high).
- R9: In comparator mode (`irq_mode_i`=0), `evt_o` equals the OR of the eligible flags as they stood one edge earlier. `clr_i` has no effect in this mode.
- R10: In interrupt mode (`irq_mode_i`=1), `evt_o` sets one edge after an eligible flag goes from 0 to 1. It then holds until a `clr_i` pulse. A new rise in the same cycle as the clear wins.
- R11: While `shdn_i` is 1, the flags keep their values and no new interrupt is raised.
- R12: A synchronous `rst` clears all three flags and `evt_o`.
- R13: Thresholds are formed in sign-extended arithmetic, so a limit near the most negative value, minus the hysteresis, does not wrap around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| temp_i | input | LIM_W+FINE_W | Temperature sample, two's complement |
| temp_vld_i | input | 1 | Sample valid strobe |
| crit_lim_i | input | LIM_W | Critical limit, 0.25 °C per LSB |
| high_lim_i | input | LIM_W | High limit |
| low_lim_i | input | LIM_W | Low limit |
| hyst_sel_i | input | 2 | Hysteresis code |
| alarm_en_i | input | 1 | Alarm enable |
| crit_only_i | input | 1 | Only the critical flag drives the alarm |
| alarm_pol_i | input | 1 | Active level of the alarm pin |
| irq_mode_i | input | 1 | 0 comparator, 1 interrupt |
| shdn_i | input | 1 | Shutdown: freeze flags, no new interrupts |
| clr_i | input | 1 | Release a latched interrupt |
| crit_o | output | 1 | Critical status flag |
| high_o | output | 1 | High status flag |
| low_o | output | 1 | Low status flag |
| alarm_pin_o | output | 1 | Alarm pin level |
| evt_o | output | 1 | Alarm asserted status |

## Verification
The bench walks samples back and forth across every threshold, once per hysteresis code. A design with asymmetric thresholds swapped, or an off-by-one comparison, would set or release a flag one step early or late. It also drives samples equal to a limit with nonzero fraction bits, where a design that compared the full-width sample would set a flag. A limit near the most negative value, minus the widest hysteresis, catches a narrow subtraction that wraps and clears or sets the low and high flags wrongly. In interrupt mode the bench checks that an alarm holds after the condition goes away, ignores a clear in comparator mode, and stays silent through shutdown. A design that leaked a clear into comparator mode, or re-raised on a level, would be caught there.

// File: rtl/thm_pkg.sv
package thm_pkg;

  localparam int NUM_FLAGS = 3;
  localparam int FLG_CRIT  = 0;
  localparam int FLG_HIGH  = 1;
  localparam int FLG_LOW   = 2;
  localparam int HYST_W    = 5;

  typedef struct packed {
    logic en;
    logic crit_only;
    logic irq_mode;
    logic shdn;
    logic clr;
  } alarm_ctrl_t;

  // quarter-degree counts for each hysteresis code (R2)
  function automatic logic [HYST_W-1:0] hyst_counts(input logic [1:0] sel);
    case (sel)
      2'd1:    hyst_counts = HYST_W'(6);
      2'd2:    hyst_counts = HYST_W'(12);
      2'd3:    hyst_counts = HYST_W'(24);
      default: hyst_counts = '0;
    endcase
  endfunction

endpackage

// File: rtl/thm_flag.sv
module thm_flag #(
  parameter int EXT_W    = 14,
  parameter bit IS_LOWER = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    upd_i,
  input  logic signed [EXT_W-1:0] temp_x_i,
  input  logic signed [EXT_W-1:0] lim_x_i,
  input  logic signed [EXT_W-1:0] hyst_x_i,
  output logic                    flag_o,
  output logic                    rise_o
);

  logic signed [EXT_W-1:0] inner_lim;
  logic flag_q, prev_q, set_c, rel_c, flag_d;

  // lower threshold of the band, wide enough not to wrap (R13)
  assign inner_lim = lim_x_i - hyst_x_i;

  generate
    if (IS_LOWER) begin : g_lower
      assign set_c = temp_x_i < inner_lim;
      assign rel_c = temp_x_i >= lim_x_i;
    end else begin : g_upper
      assign set_c = temp_x_i > lim_x_i;
      assign rel_c = temp_x_i <= inner_lim;
    end
  endgenerate

  assign flag_d = flag_q ? ~rel_c : set_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      prev_q <= flag_q;
      if (upd_i) flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;
  assign rise_o = flag_q & ~prev_q;

endmodule

// File: rtl/thm_alarm.sv
module thm_alarm #(
  parameter int NF    = thm_pkg::NUM_FLAGS,
  parameter int CRIT  = thm_pkg::FLG_CRIT
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NF-1:0]         flags_i,
  input  logic [NF-1:0]         rises_i,
  input  thm_pkg::alarm_ctrl_t  ctrl_i,
  output logic                  evt_o
);

  localparam logic [NF-1:0] CRIT_MASK = NF'(1) << CRIT;

  logic [NF-1:0] elig_mask;
  logic          level_c, fresh_c, evt_q;

  assign elig_mask = ctrl_i.crit_only ? CRIT_MASK : {NF{1'b1}};
  assign level_c   = |(flags_i & elig_mask);
  assign fresh_c   = (|(rises_i & elig_mask)) & ~ctrl_i.shdn;

  always_ff @(posedge clk) begin
    if (rst)                  evt_q <= 1'b0;
    else if (!ctrl_i.en)      evt_q <= 1'b0;
    else if (!ctrl_i.irq_mode) evt_q <= level_c;
    else if (fresh_c)         evt_q <= 1'b1;
    else if (ctrl_i.clr)      evt_q <= 1'b0;
  end

  assign evt_o = evt_q;

endmodule

// File: rtl/thm_limit_monitor.sv
module thm_limit_monitor #(
  parameter int LIM_W  = 11,
  parameter int FINE_W = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [LIM_W+FINE_W-1:0] temp_i,
  input  logic                    temp_vld_i,
  input  logic [LIM_W-1:0]        crit_lim_i,
  input  logic [LIM_W-1:0]        high_lim_i,
  input  logic [LIM_W-1:0]        low_lim_i,
  input  logic [1:0]              hyst_sel_i,
  input  logic                    alarm_en_i,
  input  logic                    crit_only_i,
  input  logic                    alarm_pol_i,
  input  logic                    irq_mode_i,
  input  logic                    shdn_i,
  input  logic                    clr_i,
  output logic                    crit_o,
  output logic                    high_o,
  output logic                    low_o,
  output logic                    alarm_pin_o,
  output logic                    evt_o
);

  localparam int TEMP_W = LIM_W + FINE_W;
  localparam int EXT_W  = LIM_W + 3;
  localparam int NF     = thm_pkg::NUM_FLAGS;

  logic signed [EXT_W-1:0] temp_x, hyst_x;
  logic signed [EXT_W-1:0] lim_x [NF];
  logic [NF-1:0]           flags, rises;
  logic                    upd;
  logic                    unused_fine;
  thm_pkg::alarm_ctrl_t    ctrl;

  // fraction bits below 0.25 degC are dropped (R1)
  assign unused_fine = ^temp_i[FINE_W-1:0];
  assign temp_x = EXT_W'($signed(temp_i[TEMP_W-1:FINE_W]));
  assign hyst_x = EXT_W'(thm_pkg::hyst_counts(hyst_sel_i));

  assign lim_x[thm_pkg::FLG_CRIT] = EXT_W'($signed(crit_lim_i));
  assign lim_x[thm_pkg::FLG_HIGH] = EXT_W'($signed(high_lim_i));
  assign lim_x[thm_pkg::FLG_LOW]  = EXT_W'($signed(low_lim_i));

  assign upd = temp_vld_i & ~shdn_i;

  generate
    for (genvar g = 0; g < NF; g++) begin : g_flag
      thm_flag #(
        .EXT_W   (EXT_W),
        .IS_LOWER(g == thm_pkg::FLG_LOW)
      ) u_flag (
        .clk     (clk),
        .rst     (rst),
        .upd_i   (upd),
        .temp_x_i(temp_x),
        .lim_x_i (lim_x[g]),
        .hyst_x_i(hyst_x),
        .flag_o  (flags[g]),
        .rise_o  (rises[g])
      );
    end
  endgenerate

  assign ctrl.en        = alarm_en_i;
  assign ctrl.crit_only = crit_only_i;
  assign ctrl.irq_mode  = irq_mode_i;
  assign ctrl.shdn      = shdn_i;
  assign ctrl.clr       = clr_i;

  thm_alarm #(
    .NF  (NF),
    .CRIT(thm_pkg::FLG_CRIT)
  ) u_alarm (
    .clk    (clk),
    .rst    (rst),
    .flags_i(flags),
    .rises_i(rises),
    .ctrl_i (ctrl),
    .evt_o  (evt_o)
  );

  assign crit_o      = flags[thm_pkg::FLG_CRIT];
  assign high_o      = flags[thm_pkg::FLG_HIGH];
  assign low_o       = flags[thm_pkg::FLG_LOW];
  assign alarm_pin_o = evt_o ? alarm_pol_i : ~alarm_pol_i;

endmodule

// File: rtl/thm_limit_monitor_chk.sv
module thm_limit_monitor_chk #(
  parameter int LIM_W  = 11,
  parameter int FINE_W = 2
) (
  input logic                    clk,
  input logic                    rst,
  input logic [LIM_W+FINE_W-1:0] temp_i,
  input logic                    temp_vld_i,
  input logic [LIM_W-1:0]        crit_lim_i,
  input logic [LIM_W-1:0]        low_lim_i,
  input logic                    alarm_en_i,
  input logic                    crit_only_i,
  input logic                    irq_mode_i,
  input logic                    shdn_i,
  input logic                    clr_i,
  input logic                    crit_o,
  input logic                    high_o,
  input logic                    low_o,
  input logic                    evt_o
);

  logic signed [LIM_W-1:0] t_s;
  assign t_s = $signed(temp_i[LIM_W+FINE_W-1:FINE_W]);

  p_reset_r12: assert property (@(posedge clk)
    rst |=> (!crit_o && !high_o && !low_o && !evt_o));

  p_crit_set_r3: assert property (@(posedge clk) disable iff (rst)
    (temp_vld_i && !shdn_i && (t_s > $signed(crit_lim_i))) |=> crit_o);

  p_low_release_r5: assert property (@(posedge clk) disable iff (rst)
    (temp_vld_i && !shdn_i && (t_s >= $signed(low_lim_i))) |=> !low_o);

  p_disable_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !alarm_en_i |=> !evt_o);

  p_cmp_follow_r9: assert property (@(posedge clk) disable iff (rst)
    (alarm_en_i && !irq_mode_i) |=>
      (evt_o == $past(crit_o || (!crit_only_i && (high_o || low_o)))));

  p_irq_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (alarm_en_i && irq_mode_i && evt_o && !clr_i) |=> evt_o);

  p_shdn_hold_r11: assert property (@(posedge clk) disable iff (rst)
    shdn_i |=> ($stable(crit_o) && $stable(high_o) && $stable(low_o)));

endmodule

bind thm_limit_monitor thm_limit_monitor_chk #(
  .LIM_W (LIM_W),
  .FINE_W(FINE_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .temp_i     (temp_i),
  .temp_vld_i (temp_vld_i),
  .crit_lim_i (crit_lim_i),
  .low_lim_i  (low_lim_i),
  .alarm_en_i (alarm_en_i),
  .crit_only_i(crit_only_i),
  .irq_mode_i (irq_mode_i),
  .shdn_i     (shdn_i),
  .clr_i      (clr_i),
  .crit_o     (crit_o),
  .high_o     (high_o),
  .low_o      (low_o),
  .evt_o      (evt_o)
);

// File: tb/thm_limit_monitor_tb_top.sv
`timescale 1ns/100ps
module thm_limit_monitor_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [12:0] temp = '0;
  logic vld = 1'b0;
  logic [10:0] crit_lim = 11'd400, high_lim = 11'd320, low_lim = 11'd40;
  logic [1:0] hsel = 2'd1;
  logic en = 1'b1, conly = 1'b0, pol = 1'b0, mode = 1'b0, shdn = 1'b0, clr = 1'b0;
  logic crit_o, high_o, low_o, pin_o, evt_o;

  int n_checks = 0, n_fail = 0;
  bit started = 1'b0, done = 1'b0;
  string tag = "R12";

  always #2.5 clk = ~clk;

  thm_limit_monitor dut_i (
    .clk(clk), .rst(rst), .temp_i(temp), .temp_vld_i(vld),
    .crit_lim_i(crit_lim), .high_lim_i(high_lim), .low_lim_i(low_lim),
    .hyst_sel_i(hsel), .alarm_en_i(en), .crit_only_i(conly),
    .alarm_pol_i(pol), .irq_mode_i(mode), .shdn_i(shdn), .clr_i(clr),
    .crit_o(crit_o), .high_o(high_o), .low_o(low_o),
    .alarm_pin_o(pin_o), .evt_o(evt_o)
  );

  // behavioural reference
  int mc = 0, mh = 0, ml = 0, pc = 0, ph = 0, pl = 0, me = 0;

  always @(posedge clk) begin
    int t, h, oc, oh, ol, lvl, rise;
    started = 1'b1;
    if (rst) begin
      mc = 0; mh = 0; ml = 0; pc = 0; ph = 0; pl = 0; me = 0;
    end else begin
      t = $signed(temp[12:2]);
      case (hsel) 0: h = 0; 1: h = 6; 2: h = 12; default: h = 24; endcase
      oc = mc; oh = mh; ol = ml;
      lvl  = conly ? oc : (oc | oh | ol);
      rise = conly ? (oc & ~pc & 1) : ((oc & ~pc) | (oh & ~ph) | (ol & ~pl));
      if (vld && !shdn) begin
        mc = oc ? int'(!(t <= $signed(crit_lim) - h)) : int'(t > $signed(crit_lim));
        mh = oh ? int'(!(t <= $signed(high_lim) - h)) : int'(t > $signed(high_lim));
        ml = ol ? int'(!(t >= $signed(low_lim)))      : int'(t < $signed(low_lim) - h);
      end
      if (!en) me = 0;
      else if (!mode) me = lvl;
      else if (rise != 0 && !shdn) me = 1;
      else if (clr) me = 0;
      pc = oc; ph = oh; pl = ol;
    end
  end

  task automatic check(input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (started && !done) begin
    check("crit_o", int'(crit_o), mc);
    check("high_o", int'(high_o), mh);
    check("low_o",  int'(low_o),  ml);
    check("evt_o",  int'(evt_o),  me);
    check("pin_o R8", int'(pin_o), me != 0 ? int'(pol) : int'(!pol));
  end

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic put(input int cnt, input int fine, input int n);
    temp = {11'(cnt), 2'(fine)};
    vld  = 1'b1;
    cyc(1);
    vld  = 1'b0;
    cyc(n);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    cyc(3);
    rst = 1'b0;
    tag = "R12"; cyc(2);

    // R4 and R2: high band under every hysteresis code
    for (int s = 0; s < 4; s++) begin
      hsel = 2'(s); tag = "R4/R2";
      put(300, 0, 2); put(321, 0, 2); put(320, 0, 2);
      put(320 - 6 * s + (s == 3 ? 6 * s - 24 : 0) + 1, 0, 2);
      put(320 - (s == 0 ? 0 : (s == 1 ? 6 : (s == 2 ? 12 : 24))), 0, 2);
      put(300, 0, 2);
    end
    hsel = 2'd1;

    // R3: critical band
    tag = "R3";
    put(401, 0, 2); put(395, 0, 2); put(394, 0, 2); put(300, 0, 2);

    // R5: low band
    tag = "R5";
    put(40, 0, 2); put(35, 0, 2); put(34, 0, 2); put(33, 0, 2);
    put(39, 0, 2); put(40, 0, 2); put(100, 0, 2);

    // R1: fraction bits at a limit do not set a flag
    tag = "R1";
    put(320, 3, 3); put(400, 3, 3); put(100, 0, 2);

    // R6: only critical drives alarm
    tag = "R6"; conly = 1'b1;
    put(330, 0, 3); put(401, 0, 3); put(100, 0, 3);
    conly = 1'b0;

    // R7: disabled alarm
    tag = "R7"; en = 1'b0;
    put(500, 0, 3); put(100, 0, 2);
    en = 1'b1;

    // R8: active-high pin
    tag = "R8"; pol = 1'b1;
    put(330, 0, 3); put(100, 0, 3);
    pol = 1'b0;

    // R9: comparator ignores clear
    tag = "R9";
    put(330, 0, 1); clr = 1'b1; cyc(2); clr = 1'b0; put(100, 0, 3);

    // R10: interrupt latch, hold, clear, re-arm, set beats clear
    tag = "R10"; mode = 1'b1;
    put(330, 0, 3); put(100, 0, 3);
    clr = 1'b1; cyc(1); clr = 1'b0; cyc(2);
    clr = 1'b1; cyc(1); clr = 1'b0; cyc(1);
    put(330, 0, 0); clr = 1'b1; cyc(2); clr = 1'b0; cyc(2);
    put(100, 0, 1); clr = 1'b1; cyc(1); clr = 1'b0; cyc(2);

    // R11: shutdown freezes flags, blocks new interrupt
    tag = "R11"; shdn = 1'b1;
    put(500, 0, 3); put(10, 0, 3);
    shdn = 1'b0; cyc(2);
    put(100, 0, 3);
    clr = 1'b1; cyc(1); clr = 1'b0; cyc(1);
    mode = 1'b0;

    // R13: limits near the most negative value
    tag = "R13"; hsel = 2'd3;
    low_lim = 11'(-1020); high_lim = 11'(-1020); crit_lim = 11'(-1010);
    put(-1024, 0, 3); put(-1000, 0, 3); put(-1024, 0, 3);
    put(-1030 + 6, 0, 3);
    cyc(2);
    finish_run();
  end

endmodule